// File: doc/BRIEF.md
# Command Completion Flag Controller

This block keeps the completion-signalling state of a host-driven arithmetic coprocessor port. The host writes a command byte through a chip-select / strobe bus. The block latches that byte, hands it to the execution core and reports busy. When the core pulses `done`, the block clears busy and raises an end-of-execution interrupt. If the command's most significant bit asked for post-execution service, it also raises a service request.

The two flags are cleared in different ways. The end flag falls on its own acknowledge, on any host access to the device, or on reset. The service request falls on its own acknowledge, on completion of a later command that does not ask for service, or on reset. Reset comes either from the `rst` pin or from a write strobe while the secondary reset select is low. All pins are plain control and status levels sampled on the rising clock edge. There is no streaming interface, so no valid/ready back-pressure applies.

Top module: `cmd_done_flags`

## Requirements
- R1: When `rst` is high, or when `rst_sel_n` and `wr_n` are both low at a clock edge, the next cycle shows `busy`=0, `end_irq`=0 and `svc_req`=0.
- R2: A command write is `cs_n`=0, `cd_sel`=1 and `wr_n`=0. When `busy`=0, it latches `din` into `cmd_byte` and sets `busy` in the next cycle.
- R3: A command write while `busy`=1 is ignored. `cmd_byte` keeps the earlier command, and its bit 7 still decides the service request at completion.
- R4: `done`=1 while `busy`=1 completes the command. In the next cycle `busy`=0, `end_irq`=1 (unless R7 clears it) and `svc_req` equals bit 7 of `cmd_byte` (unless R8 clears it).
- R5: `done`=1 while `busy`=0 has no effect on `busy`, `end_irq` or `svc_req`.
- R6: `end_ack_n`=0 during a cycle in which `end_irq` is 1 clears `end_irq` in the next cycle. With `end_ack_n` held at 0, every completion gives an `end_irq` pulse exactly one clock wide.
- R7: Any host access (`cs_n`=0 with `rd_n`=0 or `wr_n`=0) clears `end_irq` in the next cycle. An access in the completion cycle wins, and `end_irq` stays 0.
- R8: `svc_ack_n`=0 clears `svc_req` in the next cycle. In the completion cycle it wins over a set.
- R9: Completion of a command whose bit 7 is 0 clears a pending `svc_req`.
- R10: A status read is `cs_n`=0, `cd_sel`=1 and `rd_n`=0. It drives `dout` = {busy, 7'b0}. At all other times `dout` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cs_n | input | 1 | Device chip select, active low |
| rst_sel_n | input | 1 | Secondary select, active low; resets the block together with `wr_n` |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| cd_sel | input | 1 | 1 = command/status, 0 = data |
| din | input | 8 | Host write data |
| dout | output | 8 | Status read data |
| done | input | 1 | Completion pulse from the execution core |
| end_ack_n | input | 1 | End-of-execution acknowledge, active low |
| svc_ack_n | input | 1 | Service acknowledge, active low |
| cmd_byte | output | 8 | Latched command for the execution core |
| busy | output | 1 | Command in progress |
| end_irq | output | 1 | End-of-execution flag |
| svc_req | output | 1 | Service request flag |

## Verification
The completion event can share a cycle with either a host access or a service acknowledge. Both collide with a flag being set. The bench sweeps every mix of command bit 7, a pending earlier service request, a status read in the completion cycle, a service acknowledge in the completion cycle, and an end acknowledge tied low or left high. Each case is judged one cycle after completion, against the clear-beats-set rule computed in the bench. The end pulse width is then judged in the following cycle.

// File: rtl/cmd_done_flags_pkg.sv
package cmd_done_flags_pkg;

  // Events decoded from the host strobes in one cycle.
  typedef struct packed {
    logic cmd_wr;    // command write
    logic stat_rd;   // status read
    logic access;    // any read or write to the device
    logic soft_rst;  // reset requested through the secondary select
  } host_ev_t;

endpackage

// File: rtl/cmd_done_host_dec.sv
module cmd_done_host_dec
  import cmd_done_flags_pkg::*;
(
  input  logic     cs_n,
  input  logic     rst_sel_n,
  input  logic     rd_n,
  input  logic     wr_n,
  input  logic     cd_sel,
  output host_ev_t ev
);

  logic sel_rd, sel_wr;

  always_comb begin
    sel_rd      = !cs_n && !rd_n;
    sel_wr      = !cs_n && !wr_n;
    ev.cmd_wr   = sel_wr && cd_sel;
    ev.stat_rd  = sel_rd && cd_sel;
    ev.access   = sel_rd || sel_wr;
    ev.soft_rst = !rst_sel_n && !wr_n;
  end

endmodule

// File: rtl/cmd_done_cmd_reg.sv
module cmd_done_cmd_reg #(
  parameter int DATA_W  = 8,
  parameter int SVC_BIT = DATA_W - 1
) (
  input  logic              clk,
  input  logic              rst_i,
  input  logic              cmd_wr,
  input  logic [DATA_W-1:0] din,
  input  logic              done,
  output logic [DATA_W-1:0] cmd_q,
  output logic              busy,
  output logic              done_ok,
  output logic              svc_want
);

  logic accept;

  always_comb begin
    accept   = cmd_wr && !busy;
    done_ok  = done && busy;
    svc_want = cmd_q[SVC_BIT];
  end

  always_ff @(posedge clk) begin
    if (rst_i) begin
      cmd_q <= '0;
      busy  <= 1'b0;
    end else begin
      if (accept) begin
        cmd_q <= din;
        busy  <= 1'b1;
      end else if (done_ok) begin
        busy  <= 1'b0;
      end
    end
  end

  // R2
  busy_set_chk: assert property (@(posedge clk) disable iff (rst_i)
    (cmd_wr && !busy) |=> busy);

  // R3
  cmd_hold_chk: assert property (@(posedge clk) disable iff (rst_i)
    (cmd_wr && busy) |=> $stable(cmd_q));

  // R5
  idle_stays_chk: assert property (@(posedge clk) disable iff (rst_i)
    (!busy && !cmd_wr) |=> !busy);

endmodule

// File: rtl/cmd_done_flag_unit.sv
module cmd_done_flag_unit (
  input  logic clk,
  input  logic rst_i,
  input  logic done_ok,
  input  logic svc_want,
  input  logic access,
  input  logic end_ack_n,
  input  logic svc_ack_n,
  output logic end_q,
  output logic svc_q
);

  logic end_clr, svc_clr;

  always_comb begin
    // The end acknowledge acts on a flag already raised, so a tied-low
    // acknowledge leaves a one-cycle pulse; a host access beats a set.
    end_clr = access || (end_q && !end_ack_n);
    svc_clr = !svc_ack_n;
  end

  always_ff @(posedge clk) begin
    if (rst_i) begin
      end_q <= 1'b0;
      svc_q <= 1'b0;
    end else begin
      if (access)       end_q <= 1'b0;
      else if (done_ok) end_q <= 1'b1;
      else if (end_clr) end_q <= 1'b0;

      if (svc_clr)      svc_q <= 1'b0;
      else if (done_ok) svc_q <= svc_want;
    end
  end

  // R4
  end_rise_chk: assert property (@(posedge clk) disable iff (rst_i)
    (done_ok && !access) |=> end_q);

  // R6
  end_ack_chk: assert property (@(posedge clk) disable iff (rst_i)
    (end_q && !end_ack_n && !done_ok) |=> !end_q);

  // R7
  access_clr_chk: assert property (@(posedge clk) disable iff (rst_i)
    access |=> !end_q);

  // R8
  svc_ack_chk: assert property (@(posedge clk) disable iff (rst_i)
    !svc_ack_n |=> !svc_q);

  // R9
  svc_drop_chk: assert property (@(posedge clk) disable iff (rst_i)
    (done_ok && !svc_want) |=> !svc_q);

endmodule

// File: rtl/cmd_done_flags.sv
module cmd_done_flags
  import cmd_done_flags_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int SVC_BIT  = DATA_W - 1,
  parameter int BUSY_BIT = DATA_W - 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n,
  input  logic              rst_sel_n,
  input  logic              rd_n,
  input  logic              wr_n,
  input  logic              cd_sel,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] dout,
  input  logic              done,
  input  logic              end_ack_n,
  input  logic              svc_ack_n,
  output logic [DATA_W-1:0] cmd_byte,
  output logic              busy,
  output logic              end_irq,
  output logic              svc_req
);

  host_ev_t ev;
  logic     rst_i;
  logic     done_ok;
  logic     svc_want;

  cmd_done_host_dec u_dec (
    .cs_n      (cs_n),
    .rst_sel_n (rst_sel_n),
    .rd_n      (rd_n),
    .wr_n      (wr_n),
    .cd_sel    (cd_sel),
    .ev        (ev)
  );

  assign rst_i = rst || ev.soft_rst;

  cmd_done_cmd_reg #(.DATA_W(DATA_W), .SVC_BIT(SVC_BIT)) u_cmd (
    .clk      (clk),
    .rst_i    (rst_i),
    .cmd_wr   (ev.cmd_wr),
    .din      (din),
    .done     (done),
    .cmd_q    (cmd_byte),
    .busy     (busy),
    .done_ok  (done_ok),
    .svc_want (svc_want)
  );

  cmd_done_flag_unit u_flags (
    .clk       (clk),
    .rst_i     (rst_i),
    .done_ok   (done_ok),
    .svc_want  (svc_want),
    .access    (ev.access),
    .end_ack_n (end_ack_n),
    .svc_ack_n (svc_ack_n),
    .end_q     (end_irq),
    .svc_q     (svc_req)
  );

  // Status word: busy at BUSY_BIT, zeros elsewhere, only during a status read.
  for (genvar i = 0; i < DATA_W; i++) begin : g_stat
    if (i == BUSY_BIT) begin : g_busy
      assign dout[i] = ev.stat_rd && busy;
    end else begin : g_zero
      assign dout[i] = 1'b0;
    end
  end

  // R1
  reset_clear_chk: assert property (@(posedge clk)
    rst_i |=> (!busy && !end_irq && !svc_req));

  // R10
  stat_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !ev.stat_rd |-> (dout == '0));

endmodule

// File: tb/tb_cmd_done_flags.sv
module tb_cmd_done_flags;

  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst, cs_n, rst_sel_n, rd_n, wr_n, cd_sel, done, end_ack_n, svc_ack_n;
  logic [7:0] din, dout, cmd_byte;
  logic       busy, end_irq, svc_req;
  int         checks = 0;
  int         fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  cmd_done_flags dut (
    .clk(clk), .rst(rst), .cs_n(cs_n), .rst_sel_n(rst_sel_n), .rd_n(rd_n),
    .wr_n(wr_n), .cd_sel(cd_sel), .din(din), .dout(dout), .done(done),
    .end_ack_n(end_ack_n), .svc_ack_n(svc_ack_n), .cmd_byte(cmd_byte),
    .busy(busy), .end_irq(end_irq), .svc_req(svc_req)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic idle();
    rst = 0; cs_n = 1; rst_sel_n = 1; rd_n = 1; wr_n = 1; cd_sel = 0;
    din = 8'h00; done = 0; svc_ack_n = 1;
  endtask

  // One clock edge; returns at the following falling edge.
  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset();
    idle(); rst = 1; tick(); idle();
  endtask

  task automatic cmd_write(input logic [7:0] v);
    cs_n = 0; cd_sel = 1; wr_n = 0; din = v; tick(); idle();
  endtask

  task automatic complete();
    done = 1; tick(); idle();
  endtask

  task automatic run_case(input bit b7, input bit prev, input bit acc,
                          input bit sack, input bit tie);
    logic end_exp, svc_exp;
    do_reset();
    end_ack_n = tie ? 1'b0 : 1'b1;
    if (prev) begin
      cmd_write(8'h81);
      complete();
      chk("R4 prior svc set", {7'b0, svc_req}, 8'h01);
    end
    cmd_write({b7, 7'h15});
    chk("R2 busy after write", {7'b0, busy}, 8'h01);
    chk("R2 cmd latched", cmd_byte, {b7, 7'h15});
    chk("R7 end cleared by write", {7'b0, end_irq}, 8'h00);
    // status read
    cs_n = 0; cd_sel = 1; rd_n = 0; #1;
    chk("R10 status busy", dout, 8'h80);
    tick(); idle();
    // overwrite attempt while busy
    cmd_write({~b7, 7'h2A});
    chk("R3 write while busy ignored", cmd_byte, {b7, 7'h15});
    // completion cycle with optional collisions
    done = 1;
    if (acc) begin cs_n = 0; cd_sel = 1; rd_n = 0; end
    svc_ack_n = sack ? 1'b0 : 1'b1;
    tick(); idle();
    end_exp = !acc;
    svc_exp = sack ? 1'b0 : b7;
    chk("R4 busy cleared", {7'b0, busy}, 8'h00);
    chk(acc ? "R7 access beats end set" : "R4 end raised", {7'b0, end_irq}, {7'b0, end_exp});
    chk(sack ? "R8 ack beats svc set" : (prev && !b7) ? "R9 svc dropped" : "R4 svc from bit7",
        {7'b0, svc_req}, {7'b0, svc_exp});
    tick();
    chk(tie ? "R6 one-cycle end pulse" : "R6 end held", {7'b0, end_irq},
        {7'b0, tie ? 1'b0 : end_exp});
    if (!tie && end_exp) begin
      end_ack_n = 0; tick(); end_ack_n = 1;
      chk("R6 end ack clears", {7'b0, end_irq}, 8'h00);
    end
    // done while idle
    done = 1; tick(); idle();
    chk("R5 done idle busy", {7'b0, busy}, 8'h00);
    chk("R5 done idle end", {7'b0, end_irq}, 8'h00);
    chk("R5 done idle svc", {7'b0, svc_req}, {7'b0, svc_exp});
    svc_ack_n = 0; tick(); idle();
    chk("R8 svc ack clears", {7'b0, svc_req}, 8'h00);
    chk("R10 dout idle", dout, 8'h00);
    end_ack_n = 1;
  endtask

  task automatic report();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    fails++; checks++;
    $display("FAIL watchdog actual=hung expected=done");
    report();
  end

  initial begin
    idle(); end_ack_n = 1; rst = 1;
    tick(); tick(); idle();
    chk("R1 reset busy", {7'b0, busy}, 8'h00);
    chk("R1 reset end", {7'b0, end_irq}, 8'h00);
    chk("R1 reset svc", {7'b0, svc_req}, 8'h00);
    for (int c = 0; c < 32; c++)
      run_case(c[0], c[1], c[2], c[3], c[4]);
    // reset through the secondary select, with busy and svc pending
    do_reset(); end_ack_n = 1;
    cmd_write(8'h80); complete(); cmd_write(8'h80);
    chk("R1 setup busy", {7'b0, busy}, 8'h01);
    rst_sel_n = 0; wr_n = 0; tick(); idle();
    chk("R1 select reset busy", {7'b0, busy}, 8'h00);
    chk("R1 select reset svc", {7'b0, svc_req}, 8'h00);
    chk("R1 select reset end", {7'b0, end_irq}, 8'h00);
    report();
  end

endmodule